// File: doc/BRIEF.md
# ADC Conversion Sequencer with Channel Latching

This block sequences a 10-bit successive-approximation converter. Software programs it through two write strobes. One carries the run controls: enable, start, auto-trigger enable, trigger source, clock prescaler and flag clear. The other carries the channel and reference selection. Conversions begin in one of three ways: a software start bit, a rising edge on an external trigger pin, or automatic back-to-back restart in free-running mode. Each conversion lasts 13 ADC clocks. The ADC clock is the system clock divided by a programmable prescaler.

The selection register can be written at any time. The block copies it into a working register at two points. While idle it copies on every cycle. During a conversion it copies at a single moment: the first ADC clock after the conversion starts. The working selection drives the analog front end and tags each result. A write that arrives after that moment is held until a later conversion.

Selecting a new differential channel, or changing the reference field, opens a settling window counted in system clocks. A differential conversion whose selection is copied inside that window carries an "unsettled" bit alongside its result. The bit stays with that result until the next one arrives. The converter stub supplies a raw sample, and the block clamps it to the 10-bit full scale.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset the block is idle. Busy, interrupt flag, result valid, result, result channel, unsettled bit and the working selection are all zero.
- R2: With the block enabled, a control write with start set while idle raises busy on the next cycle. At completion, `resultValid` pulses for one cycle, `result` and `resultCh` update, and busy falls in single mode.
- R3: Prescaler field p gives a divide ratio of 2 when p is 0 and 2^p otherwise. A conversion completes exactly 13 × ratio system clocks after the edge that starts it.
- R4: While idle, the working selection follows the selection register with one cycle of delay. During a conversion it is copied once, on the first ADC clock after the start. Writes before that copy apply to the current conversion; writes after it do not.
- R5: Free-running mode has enable set, auto-trigger set and trigger source 0. In this mode each completion starts the next conversion on the same edge. A selection written after a completion, but after that next conversion's copy point, appears only in the result after next. Clearing enable stops conversion at once.
- R6: In external mode (enable, auto-trigger, trigger source 1), a rising edge of `extTrig` starts a conversion when idle. Rising edges during a conversion are ignored.
- R7: The interrupt flag sets on every completion. It clears on `intAck` or on a control write with flag-clear set. A completion in the same cycle wins over a clear.
- R8: Channel codes at or above 8 are differential. A selection write opens a settling window of CLK_MHZ × SETTLE_US system clocks in two cases: it changes the channel to a different differential code, or it changes the 2-bit reference field. A conversion whose copied channel is differential and whose copy falls inside the window reports `resultUnsettled` = 1. All other conversions report 0.
- R9: A raw sample above 1023 produces the result 0x3FF. Samples of 1023 or less pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control write strobe |
| wrEnable | input | 1 | Enable value written by `ctrlWr` |
| wrStart | input | 1 | Start request carried by `ctrlWr` |
| wrAutoTrig | input | 1 | Auto-trigger enable written by `ctrlWr` |
| wrTrigExt | input | 1 | Trigger source: 0 free-running, 1 external pin |
| wrFlagClr | input | 1 | Write one to clear the interrupt flag |
| wrPrescale | input | 3 | Prescaler field p (ratio 2 for p=0, else 2^p) |
| selWr | input | 1 | Selection write strobe |
| wrCh | input | 5 | Channel code; codes 8 and up are differential |
| wrRef | input | 2 | Reference: 0 external pin, 1 analog supply, 3 internal 2.56 V |
| extTrig | input | 1 | External trigger, rising-edge active |
| intAck | input | 1 | Interrupt acknowledge, clears the flag |
| sampleIn | input | 12 | Raw sample from the converter stub |
| convBusy | output | 1 | Conversion in progress |
| irqFlag | output | 1 | Conversion-complete interrupt flag |
| resultValid | output | 1 | One-cycle completion strobe |
| result | output | 10 | Clamped conversion result |
| resultCh | output | 5 | Working channel the result was taken on |
| resultUnsettled | output | 1 | Result taken inside a settling window |
| activeCh | output | 5 | Working channel selection |
| activeRef | output | 2 | Working reference selection |

## Verification
Several behaviours are checked by assertions on every cycle. These include busy rising after a start, the flag setting on each completion, and the ADC clock count staying inside the 13-tick frame. They also cover external edges never rewinding a running conversion, the idle copy of the selection, the clamp of oversized samples, and the reload of the settling counter. Other behaviours only show over the bench's scenarios. These are the exact completion cycle for each prescaler ratio, and which side of the copy point a mid-conversion write lands on in single and free-running modes. They also include how the unsettled bit depends on differential versus single-ended channels and on elapsed time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // Strobes the control half hands to the datapath half each cycle
  typedef struct packed {
    logic trackSel;  // idle: working selection follows the register
    logic latchSel;  // first ADC clock of a conversion: copy selection
    logic capture;   // last ADC clock: store result and tags
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int PRESC_W    = 3,
  parameter int CONV_TICKS = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWr,
  input  logic               wrEnable,
  input  logic               wrStart,
  input  logic               wrAutoTrig,
  input  logic               wrTrigExt,
  input  logic               wrFlagClr,
  input  logic [PRESC_W-1:0] wrPrescale,
  input  logic               extTrig,
  input  logic               intAck,
  output seqStrobe_t         strobes,
  output logic               busy,
  output logic               irqFlag
);
  localparam int DIV_W  = (1 << PRESC_W) - 1;
  localparam int TICK_W = $clog2(CONV_TICKS);
  localparam logic [DIV_W:0] ONE_FULL = 1;

  logic               enableQ, autoQ, extSelQ, extPrevQ;
  logic [PRESC_W-1:0] prescaleQ;
  logic [DIV_W-1:0]   divCnt, divLimit;
  logic [DIV_W:0]     divFull;
  logic [TICK_W-1:0]  tickCnt;
  logic tick, lastTick, extRise, swStart, hwStart, startNow, abortNow, freeRun;

  always_comb begin
    divFull  = ONE_FULL << prescaleQ;
    divLimit = (prescaleQ == '0) ? DIV_W'(1) : DIV_W'(divFull - ONE_FULL);
    tick     = busy && (divCnt == divLimit);
    lastTick = tick && (tickCnt == TICK_W'(CONV_TICKS - 1));
    extRise  = extTrig && !extPrevQ;
    abortNow = ctrlWr && !wrEnable && busy;
    swStart  = ctrlWr && wrEnable && wrStart && !busy;
    hwStart  = enableQ && autoQ && extSelQ && extRise && !busy
               && !(ctrlWr && !wrEnable);
    startNow = swStart || hwStart;
    freeRun  = enableQ && autoQ && !extSelQ;
    strobes.trackSel = !busy;
    strobes.latchSel = tick && (tickCnt == '0);
    strobes.capture  = lastTick && !abortNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ   <= 1'b0;
      autoQ     <= 1'b0;
      extSelQ   <= 1'b0;
      extPrevQ  <= 1'b0;
      prescaleQ <= '0;
      divCnt    <= '0;
      tickCnt   <= '0;
      busy      <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      extPrevQ <= extTrig;
      if (ctrlWr) begin
        enableQ   <= wrEnable;
        autoQ     <= wrAutoTrig;
        extSelQ   <= wrTrigExt;
        prescaleQ <= wrPrescale;
      end
      if (startNow) begin
        busy    <= 1'b1;
        divCnt  <= '0;
        tickCnt <= '0;
      end else if (abortNow) begin
        busy    <= 1'b0;
        divCnt  <= '0;
        tickCnt <= '0;
      end else if (tick) begin
        divCnt <= '0;
        if (lastTick) begin
          tickCnt <= '0;
          busy    <= freeRun;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end else if (busy) begin
        divCnt <= divCnt + 1'b1;
      end
      if (strobes.capture) irqFlag <= 1'b1;
      else if (intAck || (ctrlWr && wrFlagClr)) irqFlag <= 1'b0;
    end
  end

  // R2: a start request always leaves the block busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> busy);
  // R3: the ADC clock count never leaves the conversion frame
  p_tick_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(tickCnt) < CONV_TICKS));
  // R6: an external edge during a conversion never rewinds it
  p_ext_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && extRise && !lastTick && !abortNow) |=> (tickCnt >= $past(tickCnt)));
  // R7: completion sets the flag even when a clear arrives with it
  p_irq_on_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> irqFlag);
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int CH_W          = 5,
  parameter int DIFF_BASE     = 8,
  parameter int SAMPLE_W      = 12,
  parameter int RESULT_W      = 10,
  parameter int SETTLE_CYCLES = 31250
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobes,
  input  logic                selWr,
  input  logic [CH_W-1:0]     wrCh,
  input  logic [1:0]          wrRef,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [CH_W-1:0]     activeCh,
  output logic [1:0]          activeRef,
  output logic [RESULT_W-1:0] result,
  output logic [CH_W-1:0]     resultCh,
  output logic                resultUnsettled,
  output logic                resultValid
);
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SAMPLE_W-1:0] FULL_SCALE = SAMPLE_W'((1 << RESULT_W) - 1);

  logic [CH_W-1:0]     selCh;
  logic [1:0]          selRef;
  logic [SETTLE_W-1:0] settleCnt;
  logic                convUnsettled;
  logic [RESULT_W-1:0] clamped;
  logic wrDiff, selDiff, newWindow;

  always_comb begin
    wrDiff    = int'(wrCh) >= DIFF_BASE;
    selDiff   = int'(selCh) >= DIFF_BASE;
    newWindow = selWr && ((wrDiff && (wrCh != selCh)) || (wrRef != selRef));
    clamped   = (sampleIn > FULL_SCALE) ? '1 : sampleIn[RESULT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selCh           <= '0;
      selRef          <= '0;
      activeCh        <= '0;
      activeRef       <= '0;
      settleCnt       <= '0;
      convUnsettled   <= 1'b0;
      result          <= '0;
      resultCh        <= '0;
      resultUnsettled <= 1'b0;
      resultValid     <= 1'b0;
    end else begin
      if (selWr) begin
        selCh  <= wrCh;
        selRef <= wrRef;
      end
      if (newWindow) settleCnt <= SETTLE_W'(SETTLE_CYCLES);
      else if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
      if (strobes.trackSel || strobes.latchSel) begin
        activeCh  <= selCh;
        activeRef <= selRef;
      end
      if (strobes.latchSel) convUnsettled <= selDiff && (settleCnt != '0);
      resultValid <= strobes.capture;
      if (strobes.capture) begin
        result          <= clamped;
        resultCh        <= activeCh;
        resultUnsettled <= convUnsettled;
      end
    end
  end

  // R4: while idle the working selection trails the register by one cycle
  p_track_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trackSel |=> (activeCh == $past(selCh)) && (activeRef == $past(selRef)));
  // R9: an oversized sample always lands at full scale
  p_clamp_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && (sampleIn > FULL_SCALE)) |=> (result == '1));
  // R8: a qualifying selection write opens a full-length window
  p_window_open_r8: assert property (@(posedge clk) disable iff (!rstN)
    newWindow |=> (settleCnt == SETTLE_W'(SETTLE_CYCLES)));
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CH_W       = 5,
  parameter int DIFF_BASE  = 8,
  parameter int PRESC_W    = 3,
  parameter int SAMPLE_W   = 12,
  parameter int RESULT_W   = 10,
  parameter int CONV_TICKS = 13,
  parameter int CLK_MHZ    = 250,
  parameter int SETTLE_US  = 125
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  logic                wrEnable,
  input  logic                wrStart,
  input  logic                wrAutoTrig,
  input  logic                wrTrigExt,
  input  logic                wrFlagClr,
  input  logic [PRESC_W-1:0]  wrPrescale,
  input  logic                selWr,
  input  logic [CH_W-1:0]     wrCh,
  input  logic [1:0]          wrRef,
  input  logic                extTrig,
  input  logic                intAck,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                convBusy,
  output logic                irqFlag,
  output logic                resultValid,
  output logic [RESULT_W-1:0] result,
  output logic [CH_W-1:0]     resultCh,
  output logic                resultUnsettled,
  output logic [CH_W-1:0]     activeCh,
  output logic [1:0]          activeRef
);
  localparam int SETTLE_CYCLES = CLK_MHZ * SETTLE_US;

  seqStrobe_t strobes;

  adc_seq_ctrl #(.PRESC_W(PRESC_W), .CONV_TICKS(CONV_TICKS)) ctrlU (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .wrEnable(wrEnable),
    .wrStart(wrStart), .wrAutoTrig(wrAutoTrig), .wrTrigExt(wrTrigExt),
    .wrFlagClr(wrFlagClr), .wrPrescale(wrPrescale), .extTrig(extTrig),
    .intAck(intAck), .strobes(strobes), .busy(convBusy), .irqFlag(irqFlag)
  );

  adc_seq_datapath #(
    .CH_W(CH_W), .DIFF_BASE(DIFF_BASE), .SAMPLE_W(SAMPLE_W),
    .RESULT_W(RESULT_W), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) dataU (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selWr(selWr), .wrCh(wrCh),
    .wrRef(wrRef), .sampleIn(sampleIn), .activeCh(activeCh),
    .activeRef(activeRef), .result(result), .resultCh(resultCh),
    .resultUnsettled(resultUnsettled), .resultValid(resultValid)
  );
endmodule

// File: tb/adc_conv_sequencer_test.sv
`timescale 1ns/1ps
module adc_conv_sequencer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 0, wrEnable = 0, wrStart = 0, wrAutoTrig = 0, wrTrigExt = 0, wrFlagClr = 0;
  logic [2:0] wrPrescale = '0;
  logic selWr = 0;
  logic [4:0] wrCh = '0;
  logic [1:0] wrRef = '0;
  logic extTrig = 0, intAck = 0;
  logic [11:0] sampleIn = '0;
  logic convBusy, irqFlag, resultValid, resultUnsettled;
  logic [9:0] result;
  logic [4:0] resultCh, activeCh;
  logic [1:0] activeRef;

  int nTests = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  adc_conv_sequencer #(.CLK_MHZ(2)) uut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .wrEnable(wrEnable), .wrStart(wrStart),
    .wrAutoTrig(wrAutoTrig), .wrTrigExt(wrTrigExt), .wrFlagClr(wrFlagClr),
    .wrPrescale(wrPrescale), .selWr(selWr), .wrCh(wrCh), .wrRef(wrRef),
    .extTrig(extTrig), .intAck(intAck), .sampleIn(sampleIn), .convBusy(convBusy),
    .irqFlag(irqFlag), .resultValid(resultValid), .result(result), .resultCh(resultCh),
    .resultUnsettled(resultUnsettled), .activeCh(activeCh), .activeRef(activeRef)
  );

  // Vector table: prescaler field, raw sample, expected result
  localparam int N_VEC = 6;
  localparam int V_PRESC  [N_VEC] = '{0, 1, 3, 5, 7, 2};
  localparam int V_SAMPLE [N_VEC] = '{0, 512, 1023, 1024, 4095, 300};
  localparam int V_RESULT [N_VEC] = '{0, 512, 1023, 1023, 1023, 300};

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctrlWrite(input bit en, input bit st, input bit au, input bit ex,
                           input int p, input bit clr);
    ctrlWr = 1; wrEnable = en; wrStart = st; wrAutoTrig = au; wrTrigExt = ex;
    wrPrescale = 3'(p); wrFlagClr = clr;
    tick(1);
    ctrlWr = 0; wrStart = 0; wrFlagClr = 0;
  endtask

  task automatic selWrite(input int ch, input int rf);
    selWr = 1; wrCh = 5'(ch); wrRef = 2'(rf);
    tick(1);
    selWr = 0;
  endtask

  task automatic waitResult(input string req);
    int n = 0;
    tick(1);
    while (!resultValid && n < 3000) begin
      tick(1);
      n++;
    end
    checkEq(req, "result arrived", int'(resultValid), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL WDOG run did not finish: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: reset state
    checkEq("R1", "busy", int'(convBusy), 0);
    checkEq("R1", "irq", int'(irqFlag), 0);
    checkEq("R1", "valid", int'(resultValid), 0);
    checkEq("R1", "result", int'(result), 0);
    checkEq("R1", "resultCh", int'(resultCh), 0);
    checkEq("R1", "unsettled", int'(resultUnsettled), 0);
    checkEq("R1", "activeCh", int'(activeCh), 0);

    // R2/R3/R9: table of prescaler ratios and samples
    for (int i = 0; i < N_VEC; i++) begin
      int p = V_PRESC[i];
      int dv = (p == 0) ? 2 : (1 << p);
      sampleIn = 12'(V_SAMPLE[i]);
      ctrlWrite(1, 1, 0, 0, p, 0);
      checkEq("R2", "busy after start", int'(convBusy), 1);
      tick(13 * dv - 1);
      checkEq("R3", "busy one cycle before end", int'(convBusy), 1);
      checkEq("R3", "no early result", int'(resultValid), 0);
      tick(1);
      checkEq("R3", "result at 13 x ratio", int'(resultValid), 1);
      if (V_SAMPLE[i] > 1023) checkEq("R9", "clamped result", int'(result), V_RESULT[i]);
      else checkEq("R2", "result value", int'(result), V_RESULT[i]);
      checkEq("R2", "busy cleared", int'(convBusy), 0);
      checkEq("R7", "irq set on completion", int'(irqFlag), 1);
      intAck = 1;
      tick(1);
      intAck = 0;
      checkEq("R7", "irq cleared by ack", int'(irqFlag), 0);
    end

    // R4: idle tracking
    sampleIn = 12'd77;
    selWrite(3, 2);
    tick(1);
    checkEq("R4", "idle activeCh", int'(activeCh), 3);
    checkEq("R4", "idle activeRef", int'(activeRef), 2);

    // R4: write before the copy point joins the running conversion
    ctrlWrite(1, 1, 0, 0, 2, 0);
    selWrite(6, 2);
    waitResult("R4");
    checkEq("R4", "early write used", int'(resultCh), 6);

    // R4: write after the copy point waits for a later conversion
    selWrite(3, 2);
    tick(1);
    ctrlWrite(1, 1, 0, 0, 2, 0);
    tick(5);
    selWrite(7, 2);
    checkEq("R4", "working channel held", int'(activeCh), 3);
    waitResult("R4");
    checkEq("R4", "late write not used", int'(resultCh), 3);
    tick(1);
    checkEq("R4", "tracks after completion", int'(activeCh), 7);
    ctrlWrite(1, 0, 0, 0, 0, 1);
    checkEq("R7", "irq cleared by write-one", int'(irqFlag), 0);

    // R8: settling window
    selWrite(9, 1);
    ctrlWrite(1, 1, 0, 0, 0, 0);
    waitResult("R8");
    checkEq("R8", "diff inside window", int'(resultUnsettled), 1);
    checkEq("R8", "diff channel tag", int'(resultCh), 9);
    tick(300);
    ctrlWrite(1, 1, 0, 0, 0, 0);
    waitResult("R8");
    checkEq("R8", "diff after window", int'(resultUnsettled), 0);
    selWrite(9, 3);
    ctrlWrite(1, 1, 0, 0, 0, 0);
    waitResult("R8");
    checkEq("R8", "reference change reopens window", int'(resultUnsettled), 1);
    tick(300);
    selWrite(2, 3);
    ctrlWrite(1, 1, 0, 0, 0, 0);
    waitResult("R8");
    checkEq("R8", "single-ended clean", int'(resultUnsettled), 0);
    selWrite(4, 1);
    ctrlWrite(1, 1, 0, 0, 0, 0);
    waitResult("R8");
    checkEq("R8", "single-ended ignores window", int'(resultUnsettled), 0);
    selWrite(10, 1);
    ctrlWrite(1, 1, 0, 0, 0, 0);
    waitResult("R8");
    checkEq("R8", "new diff channel flagged", int'(resultUnsettled), 1);

    // R6: external trigger, edges during a conversion ignored
    begin
      int seen = 0;
      ctrlWrite(1, 0, 1, 1, 0, 1);
      extTrig = 1;
      tick(1);
      checkEq("R6", "edge starts conversion", int'(convBusy), 1);
      tick(4);
      extTrig = 0;
      tick(3);
      extTrig = 1;
      tick(2);
      extTrig = 0;
      for (int k = 0; k < 100; k++) begin
        tick(1);
        if (resultValid) seen++;
      end
      checkEq("R6", "one result only", seen, 1);
      checkEq("R6", "idle afterwards", int'(convBusy), 0);
      checkEq("R7", "irq after external run", int'(irqFlag), 1);
      intAck = 1;
      tick(1);
      intAck = 0;
      checkEq("R7", "irq ack", int'(irqFlag), 0);
    end

    // R5: free-running, late write lands on the result after next
    ctrlWrite(0, 0, 0, 0, 0, 0);
    selWrite(1, 1);
    ctrlWrite(1, 1, 1, 0, 0, 0);
    waitResult("R5");
    checkEq("R5", "first result channel", int'(resultCh), 1);
    tick(3);
    selWrite(2, 1);
    waitResult("R5");
    checkEq("R5", "next result still old channel", int'(resultCh), 1);
    checkEq("R5", "still running", int'(convBusy), 1);
    waitResult("R5");
    checkEq("R5", "result after next uses new channel", int'(resultCh), 2);
    ctrlWrite(0, 0, 0, 0, 0, 0);
    checkEq("R5", "disable stops", int'(convBusy), 0);
    begin
      int extra = 0;
      for (int k = 0; k < 60; k++) begin
        tick(1);
        if (resultValid) extra++;
      end
      checkEq("R5", "no results after disable", extra, 0);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule